// File: doc/BRIEF.md
# Bit-Synchronous Frame Receiver with Residual-Bit Status

This block receives a serial bit stream, one bit per cycle in which the bit strobe is high. It locks onto the 0x7E flag pattern that opens and closes each frame. It removes the zeros that a transmitter inserts after five consecutive ones, and it treats a run of seven or more ones as an abort. The bits between flags are packed into bytes, least significant bit first. The last sixteen bits before the closing flag form the frame check sequence. Those bits are checked against a CRC and are never handed on as data.

Each data byte enters a small receive buffer together with a status entry. The status entry marks the last byte of a frame (end of message). It also marks a final byte that holds fewer than eight bits (residual bits), and a frame whose check sequence failed. The buffer is read one entry at a time, and each read removes the data byte and its status together.

A host status byte holds two sticky flags, one for CRC errors and one for overrun; all other bits of that byte are reserved. The CRC-error flag does not change when a frame is received. It changes when a frame's last entry reaches the head of the buffer.

Top module: `hdlc_resid_rx`

## Requirements
- R1: A 0x7E flag (bit sequence 0,1,1,1,1,1,1,0) opens and closes a frame, and one flag may close one frame and open the next. Data bytes are delivered in arrival order, and the first bit received of each byte lands in bit 0.
- R2: Within a frame, a 0 that follows five consecutive 1s is deleted and does not appear in the delivered data.
- R3: The 16 bits that come just before the closing flag are the check sequence and are never delivered. A frame that carries no data bits beyond them produces no entry.
- R4: Only the last entry of a frame has `rd_eom` set to 1; every earlier entry of the frame has it at 0.
- R5: When the data of a frame ends with k bits (1 to 7) that do not fill a byte, one extra entry is delivered with `rd_eom`=1 and `rd_resid`=1. Its k bits sit in `rd_data[k-1:0]`, first received in bit 0, and the upper bits are undefined. Whole-byte frames deliver `rd_resid`=0 on every entry.
- R6: The CRC is the bit-reflected CCITT polynomial 0x8408, preset to 0xFFFF and run over the data and the check sequence; a good frame leaves 0xF0B8. With `crc_chk_en`=1, the last entry of a failing frame has `rd_crc_bad`=1. With `crc_chk_en`=0, `rd_crc_bad` is never 1.
- R7: Status bit 2 is a sticky CRC-error flag. It is updated when an end-of-message entry becomes the head of the buffer: it is set if that entry has `rd_crc_bad`=1 and cleared if it does not. A host write with bit 2 set to 1 also clears it.
- R8: Status bits 7:5, 3 and 1:0 are reserved. They always read 0, and writing 1s to them changes no status bit.
- R9: Seven or more consecutive 1s abort the frame in progress. No entry with `rd_eom`=1 is produced for it, and its bytes still held back are discarded. The receiver then waits for a new flag.
- R10: The buffer holds 4 entries and delivers them in order, with data and status popped together by `rd_pop`. A byte that arrives while the buffer is full is dropped and sets status bit 4. Bit 4 is sticky and is cleared by a host write with bit 4 set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Serial receive data |
| rx_bit_vld | input | 1 | `rx_bit` carries a new bit this cycle |
| crc_chk_en | input | 1 | 1 enables CRC error reporting |
| rd_pop | input | 1 | Remove the head entry of the buffer |
| rd_valid | output | 1 | The buffer holds at least one entry |
| rd_data | output | 8 | Data byte of the head entry |
| rd_eom | output | 1 | Head entry is the last of its frame |
| rd_resid | output | 1 | Head entry is a partial final byte |
| rd_crc_bad | output | 1 | Head entry closes a frame whose CRC failed |
| host_wr | input | 1 | Host write strobe for the status byte |
| host_wdata | input | 8 | Host write data; a 1 clears the matching sticky flag |
| status | output | 8 | Status byte: bit 2 CRC error, bit 4 overrun, others 0 |

## Verification
The assertions check, on every cycle, the timing rules that hold between the parts of the block. A delivered bit always follows a strobed input bit. An entry marked residual is always an end-of-message entry. With checking switched off, no entry ever carries a CRC error. The CRC-error flag rises only after an erroring end-of-message entry has been at the head, and a push into a full buffer always raises the overrun flag. Only the bench's scenarios can show the rest. That covers the bytes recovered after zero deletion, the exclusion of the check sequence, and the packing of residual bits. It also covers the discarding of aborted frames, the clearing of the sticky flags by host writes and by a later good frame, and the order of entries when the buffer overflows.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    localparam int BYTE_W    = 8;
    localparam int FCS_BITS  = 16;
    // leading 0 and five 1s of the closing flag are emitted before it is recognised
    localparam int FLAG_TAIL = 6;
    localparam int HOLD_BITS = FCS_BITS + FLAG_TAIL;

    localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_RF = 16'h8408;
    localparam logic [15:0] CRC_GOOD    = 16'hF0B8;

    localparam int ST_CRC_BIT = 2;
    localparam int ST_OVR_BIT = 4;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              eom;
        logic              resid;
        logic              crc_bad;
    } rx_entry_t;

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        return (c >> 1) ^ (fb ? CRC_POLY_RF : 16'h0000);
    endfunction

endpackage

// File: rtl/rx_deframer.sv
module rx_deframer
    import hdlc_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    input  logic bit_vld,
    output logic d_stb,
    output logic d_bit,
    output logic flag_seen,
    output logic abort_seen
);

    logic [2:0] ones;
    logic       hunting;

    always_ff @(posedge clk) begin
        if (rst) begin
            ones       <= '0;
            hunting    <= 1'b1;
            d_stb      <= 1'b0;
            d_bit      <= 1'b0;
            flag_seen  <= 1'b0;
            abort_seen <= 1'b0;
        end else begin
            d_stb      <= 1'b0;
            flag_seen  <= 1'b0;
            abort_seen <= 1'b0;
            if (bit_vld) begin
                if (bit_in) begin
                    if (ones != 3'd7) ones <= ones + 3'd1;
                    if (ones == 3'd6) begin
                        abort_seen <= !hunting;
                        hunting    <= 1'b1;
                    end
                    if (ones < 3'd5 && !hunting) begin
                        d_stb <= 1'b1;
                        d_bit <= 1'b1;
                    end
                end else begin
                    ones <= '0;
                    if (ones == 3'd6) begin
                        flag_seen <= 1'b1;
                        hunting   <= 1'b0;
                    end else if (ones < 3'd5 && !hunting) begin
                        d_stb <= 1'b1;
                        d_bit <= 1'b0;
                    end
                end
            end
        end
    end

    assert_data_from_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        d_stb |-> $past(bit_vld));

endmodule

// File: rtl/rx_assembler.sv
module rx_assembler
    import hdlc_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      d_stb,
    input  logic      d_bit,
    input  logic      flag_seen,
    input  logic      abort_seen,
    input  logic      crc_en,
    output logic      push,
    output rx_entry_t push_entry
);

    localparam int CW = $clog2(HOLD_BITS + 1);
    localparam int PCW = $clog2(BYTE_W);

    logic [HOLD_BITS-1:0] sr;
    logic [CW-1:0]        cnt;
    logic [15:0]          crc;
    logic [BYTE_W-1:0]    part;
    logic [PCW-1:0]       pcnt;
    logic [BYTE_W-1:0]    held;
    logic                 held_v;

    logic                 out_bit;
    logic [BYTE_W-1:0]    part_nx;
    logic [PCW:0]         gap;

    assign out_bit = sr[HOLD_BITS-1];
    assign part_nx = {out_bit, part[BYTE_W-1:1]};
    assign gap     = (PCW+1)'(BYTE_W) - {1'b0, pcnt};

    always_ff @(posedge clk) begin
        if (rst) begin
            sr         <= '0;
            cnt        <= '0;
            crc        <= CRC_PRESET;
            part       <= '0;
            pcnt       <= '0;
            held       <= '0;
            held_v     <= 1'b0;
            push       <= 1'b0;
            push_entry <= '0;
        end else begin
            push <= 1'b0;
            if (flag_seen || abort_seen) begin
                if (flag_seen && (held_v || pcnt != '0)) begin
                    push               <= 1'b1;
                    push_entry.eom     <= 1'b1;
                    push_entry.crc_bad <= crc_en && (crc != CRC_GOOD);
                    if (pcnt == '0) begin
                        push_entry.data  <= held;
                        push_entry.resid <= 1'b0;
                    end else begin
                        push_entry.data  <= part >> gap;
                        push_entry.resid <= 1'b1;
                    end
                end
                sr     <= '0;
                cnt    <= '0;
                crc    <= CRC_PRESET;
                part   <= '0;
                pcnt   <= '0;
                held_v <= 1'b0;
            end else if (d_stb) begin
                sr <= {sr[HOLD_BITS-2:0], d_bit};
                if (cnt >= CW'(FLAG_TAIL)) crc <= crc_step(crc, sr[FLAG_TAIL-1]);
                if (cnt == CW'(HOLD_BITS)) begin
                    part <= part_nx;
                    if (pcnt == PCW'(BYTE_W-1)) begin
                        held   <= part_nx;
                        held_v <= 1'b1;
                        pcnt   <= '0;
                    end else begin
                        pcnt <= pcnt + PCW'(1);
                    end
                    if (pcnt == '0 && held_v) begin
                        push               <= 1'b1;
                        push_entry.data    <= held;
                        push_entry.eom     <= 1'b0;
                        push_entry.resid   <= 1'b0;
                        push_entry.crc_bad <= 1'b0;
                        held_v             <= 1'b0;
                    end
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    assert_resid_only_at_end_R5: assert property (@(posedge clk) disable iff (rst)
        (push && push_entry.resid) |-> push_entry.eom);

    assert_crc_off_never_flags_R6: assert property (@(posedge clk) disable iff (rst)
        (push && !$past(crc_en)) |-> !push_entry.crc_bad);

endmodule

// File: rtl/rx_stat_fifo.sv
module rx_stat_fifo
    import hdlc_rx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  rx_entry_t push_entry,
    input  logic      pop,
    output rx_entry_t head,
    output logic      valid,
    output logic      full
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    rx_entry_t     mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [PW:0]   cnt;
    logic          push_ok, pop_ok;

    assign valid   = (cnt != '0);
    assign full    = (cnt == (PW+1)'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && valid;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= push_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push_ok) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + PW'(1);
            if (pop_ok)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + PW'(1);
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + (PW+1)'(1);
                2'b01:   cnt <= cnt - (PW+1)'(1);
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/hdlc_resid_rx.sv
module hdlc_resid_rx
    import hdlc_rx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_bit,
    input  logic        rx_bit_vld,
    input  logic        crc_chk_en,
    input  logic        rd_pop,
    output logic        rd_valid,
    output logic [7:0]  rd_data,
    output logic        rd_eom,
    output logic        rd_resid,
    output logic        rd_crc_bad,
    input  logic        host_wr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  status
);

    logic      d_stb, d_bit, flag_seen, abort_seen;
    logic      push, full;
    rx_entry_t push_entry, head;
    logic      prev_valid, prev_pop, arrive;
    logic      crc_flag, ovr_flag;

    rx_deframer u_deframer (
        .clk(clk), .rst(rst), .bit_in(rx_bit), .bit_vld(rx_bit_vld),
        .d_stb(d_stb), .d_bit(d_bit), .flag_seen(flag_seen), .abort_seen(abort_seen)
    );

    rx_assembler u_assembler (
        .clk(clk), .rst(rst), .d_stb(d_stb), .d_bit(d_bit),
        .flag_seen(flag_seen), .abort_seen(abort_seen), .crc_en(crc_chk_en),
        .push(push), .push_entry(push_entry)
    );

    rx_stat_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .push_entry(push_entry),
        .pop(rd_pop), .head(head), .valid(rd_valid), .full(full)
    );

    assign rd_data    = head.data;
    assign rd_eom     = head.eom;
    assign rd_resid   = head.resid;
    assign rd_crc_bad = head.crc_bad;

    // a new entry is at the head when the buffer was empty or was popped last cycle
    assign arrive = rd_valid && (!prev_valid || prev_pop);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_valid <= 1'b0;
            prev_pop   <= 1'b0;
            crc_flag   <= 1'b0;
            ovr_flag   <= 1'b0;
        end else begin
            prev_valid <= rd_valid;
            prev_pop   <= rd_pop && rd_valid;
            if (arrive && head.eom)                     crc_flag <= head.crc_bad;
            else if (host_wr && host_wdata[ST_CRC_BIT]) crc_flag <= 1'b0;
            if (push && full)                           ovr_flag <= 1'b1;
            else if (host_wr && host_wdata[ST_OVR_BIT]) ovr_flag <= 1'b0;
        end
    end

    always_comb begin
        status             = '0;
        status[ST_CRC_BIT] = crc_flag;
        status[ST_OVR_BIT] = ovr_flag;
    end

    assert_crc_flag_from_head_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(crc_flag) |-> $past(rd_valid && rd_eom && rd_crc_bad));

    assert_overrun_raises_flag_R10: assert property (@(posedge clk) disable iff (rst)
        (push && full) |=> status[ST_OVR_BIT]);

endmodule

// File: tb/tb_hdlc_resid_rx.sv
module tb_hdlc_resid_rx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_bit = 1'b0, rx_bit_vld = 1'b0, crc_chk_en = 1'b1;
    logic       rd_pop = 1'b0, host_wr = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic       rd_valid, rd_eom, rd_resid, rd_crc_bad;
    logic [7:0] rd_data, status;

    int checks = 0, errors = 0;
    int tx_ones = 0;
    logic [7:0] fbytes [0:7];

    always #4 clk = ~clk;

    hdlc_resid_rx dut (
        .clk(clk), .rst(rst), .rx_bit(rx_bit), .rx_bit_vld(rx_bit_vld),
        .crc_chk_en(crc_chk_en), .rd_pop(rd_pop), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_eom(rd_eom), .rd_resid(rd_resid),
        .rd_crc_bad(rd_crc_bad), .host_wr(host_wr), .host_wdata(host_wdata),
        .status(status)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic b);
        if (c[0] ^ b) return (c >> 1) ^ 16'h8408;
        return c >> 1;
    endfunction

    task automatic raw_bit(input logic b);
        @(negedge clk);
        rx_bit = b;
        rx_bit_vld = 1'b1;
        @(negedge clk);
        rx_bit_vld = 1'b0;
    endtask

    task automatic send_flag();
        raw_bit(1'b0);
        for (int i = 0; i < 6; i++) raw_bit(1'b1);
        raw_bit(1'b0);
        tx_ones = 0;
    endtask

    task automatic stuff_bit(input logic b);
        raw_bit(b);
        if (b) begin
            tx_ones++;
            if (tx_ones == 5) begin
                raw_bit(1'b0);
                tx_ones = 0;
            end
        end else begin
            tx_ones = 0;
        end
    endtask

    task automatic send_frame(input int nbytes, input int rn, input logic [7:0] rv,
                              input bit corrupt);
        logic [15:0] c;
        logic [15:0] fcs;
        c = 16'hFFFF;
        send_flag();
        for (int i = 0; i < nbytes; i++)
            for (int j = 0; j < 8; j++) begin
                c = crc_upd(c, fbytes[i][j]);
                stuff_bit(fbytes[i][j]);
            end
        for (int j = 0; j < rn; j++) begin
            c = crc_upd(c, rv[j]);
            stuff_bit(rv[j]);
        end
        fcs = ~c;
        if (corrupt) fcs[0] = ~fcs[0];
        for (int j = 0; j < 16; j++) stuff_bit(fcs[j]);
        send_flag();
        repeat (6) @(negedge clk);
    endtask

    task automatic pop_check(input string req, input logic [7:0] exp_d, input logic [7:0] mask,
                             input logic exp_eom, input logic exp_res, input logic exp_crc);
        check(rd_valid === 1'b1, req, "entry present", 16'(rd_valid), 16'd1);
        check((rd_data & mask) === (exp_d & mask), req, "data", 16'(rd_data & mask), 16'(exp_d & mask));
        check(rd_eom === exp_eom, req, "eom", 16'(rd_eom), 16'(exp_eom));
        check(rd_resid === exp_res, req, "resid", 16'(rd_resid), 16'(exp_res));
        check(rd_crc_bad === exp_crc, req, "crc_bad", 16'(rd_crc_bad), 16'(exp_crc));
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic host_write(input logic [7:0] v);
        host_wr = 1'b1;
        host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
        host_wdata = 8'h00;
        @(negedge clk);
    endtask

    task automatic expect_empty(input string req);
        check(rd_valid === 1'b0, req, "buffer empty", 16'(rd_valid), 16'd0);
    endtask

    task automatic test_reset();
        check(rd_valid === 1'b0, "R10", "reset valid", 16'(rd_valid), 16'd0);
        check(status === 8'h00, "R8", "reset status", 16'(status), 16'h0);
    endtask

    task automatic test_good_frame();
        fbytes[0] = 8'h81; fbytes[1] = 8'h42; fbytes[2] = 8'hC3;
        send_frame(3, 0, 8'h00, 1'b0);
        pop_check("R1", 8'h81, 8'hFF, 1'b0, 1'b0, 1'b0);
        pop_check("R4", 8'h42, 8'hFF, 1'b0, 1'b0, 1'b0);
        pop_check("R3", 8'hC3, 8'hFF, 1'b1, 1'b0, 1'b0);
        expect_empty("R3");
    endtask

    task automatic test_stuffing();
        fbytes[0] = 8'hFF; fbytes[1] = 8'h7E; fbytes[2] = 8'h3F; fbytes[3] = 8'hF8;
        send_frame(4, 0, 8'h00, 1'b0);
        pop_check("R2", 8'hFF, 8'hFF, 1'b0, 1'b0, 1'b0);
        pop_check("R2", 8'h7E, 8'hFF, 1'b0, 1'b0, 1'b0);
        pop_check("R2", 8'h3F, 8'hFF, 1'b0, 1'b0, 1'b0);
        pop_check("R2", 8'hF8, 8'hFF, 1'b1, 1'b0, 1'b0);
        expect_empty("R2");
    endtask

    task automatic test_residual();
        fbytes[0] = 8'hA5; fbytes[1] = 8'h3C;
        send_frame(2, 5, 8'h16, 1'b0);
        pop_check("R5", 8'hA5, 8'hFF, 1'b0, 1'b0, 1'b0);
        pop_check("R5", 8'h3C, 8'hFF, 1'b0, 1'b0, 1'b0);
        pop_check("R5", 8'h16, 8'h1F, 1'b1, 1'b1, 1'b0);
        expect_empty("R5");
    endtask

    task automatic test_crc_error();
        crc_chk_en = 1'b1;
        fbytes[0] = 8'h55; fbytes[1] = 8'h0F;
        send_frame(2, 0, 8'h00, 1'b1);
        pop_check("R6", 8'h55, 8'hFF, 1'b0, 1'b0, 1'b0);
        pop_check("R6", 8'h0F, 8'hFF, 1'b1, 1'b0, 1'b1);
        repeat (2) @(negedge clk);
        check(status === 8'h04, "R7", "sticky set", 16'(status), 16'h04);
        host_write(8'hEB);
        check(status === 8'h04, "R8", "reserved write", 16'(status), 16'h04);
        host_write(8'h04);
        check(status === 8'h00, "R7", "write-1 clear", 16'(status), 16'h00);
    endtask

    task automatic test_crc_disabled();
        crc_chk_en = 1'b0;
        fbytes[0] = 8'h99;
        send_frame(1, 0, 8'h00, 1'b1);
        pop_check("R6", 8'h99, 8'hFF, 1'b1, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        check(status === 8'h00, "R6", "no flag when disabled", 16'(status), 16'h00);
        crc_chk_en = 1'b1;
    endtask

    task automatic test_clear_by_good();
        fbytes[0] = 8'h11;
        send_frame(1, 0, 8'h00, 1'b1);
        pop_check("R7", 8'h11, 8'hFF, 1'b1, 1'b0, 1'b1);
        repeat (2) @(negedge clk);
        check(status[2] === 1'b1, "R7", "flag after bad", 16'(status), 16'h04);
        fbytes[0] = 8'h22;
        send_frame(1, 0, 8'h00, 1'b0);
        repeat (2) @(negedge clk);
        check(status === 8'h00, "R7", "cleared by good frame", 16'(status), 16'h00);
        pop_check("R7", 8'h22, 8'hFF, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic test_abort();
        send_flag();
        for (int i = 0; i < 8; i++) stuff_bit(i[0]);
        for (int i = 0; i < 8; i++) stuff_bit(i[1]);
        for (int i = 0; i < 8; i++) raw_bit(1'b1);
        raw_bit(1'b0);
        repeat (6) @(negedge clk);
        expect_empty("R9");
        fbytes[0] = 8'h6D; fbytes[1] = 8'hB2;
        send_frame(2, 0, 8'h00, 1'b0);
        pop_check("R9", 8'h6D, 8'hFF, 1'b0, 1'b0, 1'b0);
        pop_check("R9", 8'hB2, 8'hFF, 1'b1, 1'b0, 1'b0);
        expect_empty("R9");
    endtask

    task automatic test_overrun();
        for (int i = 0; i < 6; i++) fbytes[i] = 8'(8'h30 + i);
        send_frame(6, 0, 8'h00, 1'b0);
        check(status === 8'h10, "R10", "overrun flag", 16'(status), 16'h10);
        for (int i = 0; i < 4; i++) pop_check("R10", 8'(8'h30 + i), 8'hFF, 1'b0, 1'b0, 1'b0);
        expect_empty("R10");
        host_write(8'h10);
        check(status === 8'h00, "R10", "overrun clear", 16'(status), 16'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_good_frame();
        test_stuffing();
        test_residual();
        test_crc_error();
        test_crc_disabled();
        test_clear_by_good();
        test_abort();
        test_overrun();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule